// File: doc/BRIEF.md
# Clock-Gated Synchronous Reset Sequencer

This block applies a synchronous reset to a large design whose reset network is too slow to meet single-cycle timing. The design clock must run through a clock-gating cell, and that cell takes its enable from this block. The block never changes the reset line while the design clock is running. It stops the clock, changes the reset, waits for the change to reach every flop, and only then starts the clock again.

A one-cycle request starts the sequence. The request may be an external asynchronous reset that has already been synchronized on both edges. The sequence has six phases:
1. Stop the design clock and wait for it to halt everywhere.
2. Raise the design reset with the clock still stopped, and wait for the assertion to spread.
3. Run the clock for a set number of cycles with the reset held.
4. Stop the clock again.
5. Drop the reset and wait for the release to spread.
6. Return to the idle phase, with the clock running and the reset low.

Each wait is its own parameter, and all the waits share one reloading down-counter. The clock-gating cell and the physical reset tree are outside this block.

Top module: `gated_reset_sequencer`

## Requirements
- R1: While the sequencer's own synchronous reset `rst_i` is high, and in the cycle after it is sampled high (even in the middle of a sequence), the outputs read `clk_en_o`=1, `design_rst_o`=0 and `busy_o`=0.
- R2: When `req_i` is high at a clock edge in idle, then starting in the next cycle `clk_en_o` is 0, `design_rst_o` is 0 and `busy_o` is 1, for exactly STOP_CYC cycles.
- R3: The next ASSERT_CYC cycles show `clk_en_o`=0 and `design_rst_o`=1.
- R4: The next ACTIVE_CYC cycles show `clk_en_o`=1 and `design_rst_o`=1.
- R5: The next STOP_CYC cycles show `clk_en_o`=0 and `design_rst_o`=1.
- R6: The next RELEASE_CYC cycles show `clk_en_o`=0 and `design_rst_o`=0.
- R7: After those phases the block returns to idle (`clk_en_o`=1, `design_rst_o`=0, `busy_o`=0). `busy_o` is therefore high for exactly 2*STOP_CYC+ASSERT_CYC+ACTIVE_CYC+RELEASE_CYC cycles.
- R8: A request that arrives while a sequence is in progress is ignored. This includes a request in the last busy cycle. Such a request neither restarts nor extends the sequence.
- R9: `busy_o` is 1 in every cycle outside idle and 0 in idle.
- R10: `design_rst_o` changes only while `clk_en_o` is 0, both in the cycle before the change and in the cycle of the change. The two outputs never change in the same cycle.
- R11: A request in the first idle cycle after a sequence ends starts a new, complete sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Ungated clock |
| rst_i | input | 1 | Synchronous active-high reset of the sequencer |
| req_i | input | 1 | One-cycle reset request |
| clk_en_o | output | 1 | Enable for the design clock-gating cell |
| design_rst_o | output | 1 | Synchronous active-high reset to the design |
| busy_o | output | 1 | High while a sequence is in progress |

## Verification
The bench builds the block with STOP_CYC=1, ASSERT_CYC=3, ACTIVE_CYC=2 and RELEASE_CYC=4. The minimum count of 1 in the clock-stop phases tests the case where the counter is loaded with zero and the phase leaves on its first edge. The unequal counts in the other phases make every phase boundary appear in a distinct cycle, so a count shifted by one or a swapped phase shows up as a miscompare. The 11-cycle sequence is short enough to cover several cases: a back-to-back request, requests in the middle and in the last busy cycle, and a sequencer reset in the middle of a sequence.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE    = 3'd0,
    SQ_HALT1   = 3'd1,
    SQ_ASSERT  = 3'd2,
    SQ_SOAK    = 3'd3,
    SQ_HALT2   = 3'd4,
    SQ_RELEASE = 3'd5
  } seq_state_e;

  typedef struct packed {
    logic clk_en;
    logic drst;
    logic busy;
  } seq_outs_t;

  function automatic seq_outs_t decode_outs(seq_state_e st);
    seq_outs_t o;
    o.busy = (st != SQ_IDLE);
    case (st)
      SQ_IDLE:    begin o.clk_en = 1'b1; o.drst = 1'b0; end
      SQ_HALT1:   begin o.clk_en = 1'b0; o.drst = 1'b0; end
      SQ_ASSERT:  begin o.clk_en = 1'b0; o.drst = 1'b1; end
      SQ_SOAK:    begin o.clk_en = 1'b1; o.drst = 1'b1; end
      SQ_HALT2:   begin o.clk_en = 1'b0; o.drst = 1'b1; end
      SQ_RELEASE: begin o.clk_en = 1'b0; o.drst = 1'b0; end
      default:    begin o.clk_en = 1'b1; o.drst = 1'b0; end
    endcase
    return o;
  endfunction

endpackage

// File: rtl/seq_wait_counter.sv
module seq_wait_counter #(
  parameter int CW    = 3,
  parameter int LIMIT = 4
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)              cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // The shared counter never holds more than the largest wait minus one (R7)
  assert_cnt_bound_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    int'(cnt_q) < LIMIT);

endmodule

// File: rtl/seq_phase_fsm.sv
module seq_phase_fsm
  import rst_seq_pkg::*;
#(
  parameter int CW          = 3,
  parameter int STOP_CYC    = 2,
  parameter int ASSERT_CYC  = 4,
  parameter int ACTIVE_CYC  = 3,
  parameter int RELEASE_CYC = 5
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          req_i,
  input  logic          cnt_zero_i,
  output seq_state_e    state_q_o,
  output seq_state_e    state_d_o,
  output logic          load_o,
  output logic [CW-1:0] load_val_o
);

  localparam logic [CW-1:0] LD_STOP    = CW'(STOP_CYC - 1);
  localparam logic [CW-1:0] LD_ASSERT  = CW'(ASSERT_CYC - 1);
  localparam logic [CW-1:0] LD_ACTIVE  = CW'(ACTIVE_CYC - 1);
  localparam logic [CW-1:0] LD_RELEASE = CW'(RELEASE_CYC - 1);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      SQ_IDLE:    if (req_i)      state_d = SQ_HALT1;
      SQ_HALT1:   if (cnt_zero_i) state_d = SQ_ASSERT;
      SQ_ASSERT:  if (cnt_zero_i) state_d = SQ_SOAK;
      SQ_SOAK:    if (cnt_zero_i) state_d = SQ_HALT2;
      SQ_HALT2:   if (cnt_zero_i) state_d = SQ_RELEASE;
      SQ_RELEASE: if (cnt_zero_i) state_d = SQ_IDLE;
      default:                    state_d = SQ_IDLE;
    endcase
  end

  always_comb begin
    case (state_d)
      SQ_HALT1:   load_val_o = LD_STOP;
      SQ_ASSERT:  load_val_o = LD_ASSERT;
      SQ_SOAK:    load_val_o = LD_ACTIVE;
      SQ_HALT2:   load_val_o = LD_STOP;
      SQ_RELEASE: load_val_o = LD_RELEASE;
      default:    load_val_o = '0;
    endcase
  end

  assign load_o = (state_d != state_q);

  always_ff @(posedge clk_i) begin
    if (rst_i) state_q <= SQ_IDLE;
    else       state_q <= state_d;
  end

  assign state_q_o = state_q;
  assign state_d_o = state_d;

  // A request in the middle of a sequence does not send the phase back to the start (R8)
  assert_req_ignored_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q != SQ_IDLE && state_q != SQ_RELEASE && req_i) |=> state_q != SQ_HALT1 || $past(state_q) == SQ_HALT1);

  // A phase holds while its wait is still running (R9)
  assert_phase_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_q != SQ_IDLE && !cnt_zero_i) |=> state_q == $past(state_q));

endmodule

// File: rtl/seq_out_reg.sv
module seq_out_reg
  import rst_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  seq_state_e state_d_i,
  output logic       clk_en_o,
  output logic       drst_o,
  output logic       busy_o
);

  seq_outs_t nxt;

  always_comb nxt = decode_outs(state_d_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      clk_en_o <= 1'b1;
      drst_o   <= 1'b0;
      busy_o   <= 1'b0;
    end else begin
      clk_en_o <= nxt.clk_en;
      drst_o   <= nxt.drst;
      busy_o   <= nxt.busy;
    end
  end

  // The reset edge only moves while the clock is stopped on both sides of it (R10)
  assert_rst_edge_gated_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(drst_o) |-> (!clk_en_o && !$past(clk_en_o)));

  // The end of a sequence leaves the clock running and the reset low (R7)
  assert_done_clean_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(busy_o) |-> (clk_en_o && !drst_o));

  // A sequence starts with the clock stopped and the reset low (R2)
  assert_start_gated_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(busy_o) |-> (!clk_en_o && !drst_o));

endmodule

// File: rtl/gated_reset_sequencer.sv
module gated_reset_sequencer
  import rst_seq_pkg::*;
#(
  parameter int STOP_CYC    = 2,
  parameter int ASSERT_CYC  = 4,
  parameter int ACTIVE_CYC  = 3,
  parameter int RELEASE_CYC = 5
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic req_i,
  output logic clk_en_o,
  output logic design_rst_o,
  output logic busy_o
);

  localparam int MAX_AB  = (STOP_CYC > ASSERT_CYC) ? STOP_CYC : ASSERT_CYC;
  localparam int MAX_CD  = (ACTIVE_CYC > RELEASE_CYC) ? ACTIVE_CYC : RELEASE_CYC;
  localparam int MAX_CNT = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CW      = (MAX_CNT > 1) ? $clog2(MAX_CNT) : 1;

  seq_state_e    state_q, state_d;
  logic          cnt_load, cnt_zero;
  logic [CW-1:0] cnt_load_val;

  seq_phase_fsm #(
    .CW(CW), .STOP_CYC(STOP_CYC), .ASSERT_CYC(ASSERT_CYC),
    .ACTIVE_CYC(ACTIVE_CYC), .RELEASE_CYC(RELEASE_CYC)
  ) u_fsm (
    .clk_i(clk_i), .rst_i(rst_i), .req_i(req_i), .cnt_zero_i(cnt_zero),
    .state_q_o(state_q), .state_d_o(state_d),
    .load_o(cnt_load), .load_val_o(cnt_load_val)
  );

  seq_wait_counter #(.CW(CW), .LIMIT(MAX_CNT)) u_cnt (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(cnt_load),
    .load_val_i(cnt_load_val), .zero_o(cnt_zero)
  );

  seq_out_reg u_out (
    .clk_i(clk_i), .rst_i(rst_i), .state_d_i(state_d),
    .clk_en_o(clk_en_o), .drst_o(design_rst_o), .busy_o(busy_o)
  );

  // A request seen in idle starts the sequence with the clock gated (R2)
  assert_req_starts_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (!busy_o && req_i) |=> (busy_o && !clk_en_o && !design_rst_o));

  // Clocking the design while in reset only happens inside a sequence (R4)
  assert_soak_busy_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (clk_en_o && design_rst_o) |-> busy_o);

  // The busy flag tracks the phase register (R9)
  assert_busy_phase_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    busy_o == (state_q != SQ_IDLE));

endmodule

// File: tb/sim_gated_reset_sequencer.sv
module sim_gated_reset_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int S = 1;
  localparam int A = 3;
  localparam int C = 2;
  localparam int R = 4;
  localparam int L = 2 * S + A + C + R;

  typedef struct {
    logic  ce;
    logic  rst;
    logic  busy;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_i = 1'b1;
  logic req_i = 1'b0;
  logic clk_en_o, design_rst_o, busy_o;

  int   n_vec  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;
  exp_t sb[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  gated_reset_sequencer #(
    .STOP_CYC(S), .ASSERT_CYC(A), .ACTIVE_CYC(C), .RELEASE_CYC(R)
  ) u0 (
    .clk_i(clk), .rst_i(rst_i), .req_i(req_i),
    .clk_en_o(clk_en_o), .design_rst_o(design_rst_o), .busy_o(busy_o)
  );

  function automatic void push(logic ce, logic rs, logic bz, string tag);
    exp_t e;
    e.ce = ce; e.rst = rs; e.busy = bz; e.tag = tag;
    sb.push_back(e);
  endfunction

  function automatic void push_seq();
    for (int i = 0; i < S; i++) push(1'b0, 1'b0, 1'b1, "R2");
    for (int i = 0; i < A; i++) push(1'b0, 1'b1, 1'b1, "R3");
    for (int i = 0; i < C; i++) push(1'b1, 1'b1, 1'b1, "R4");
    for (int i = 0; i < S; i++) push(1'b0, 1'b1, 1'b1, "R5");
    for (int i = 0; i < R; i++) push(1'b0, 1'b0, 1'b1, "R6");
  endfunction

  // Monitor: compare the outputs against the scoreboard, away from the edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_vec++;
      if (clk_en_o !== e.ce || design_rst_o !== e.rst || busy_o !== e.busy) begin
        n_fail++;
        $display("FAIL %s: got ce=%b rst=%b busy=%b, expected ce=%b rst=%b busy=%b",
                 e.tag, clk_en_o, design_rst_o, busy_o, e.ce, e.rst, e.busy);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic idle_cycles(int n, string tag);
    for (int i = 0; i < n; i++) begin
      push(1'b1, 1'b0, 1'b0, tag);
      step();
    end
  endtask

  // Driver: issue a request in idle; the expected sequence follows
  task automatic issue_req(string tag);
    req_i = 1'b1;
    push(1'b1, 1'b0, 1'b0, tag);
    push_seq();
    step();
    req_i = 1'b0;
  endtask

  initial begin
    // R1: reset state while held in reset
    step();
    idle_cycles(3, "R1");
    rst_i = 1'b0;
    idle_cycles(2, "R1");

    // Plain sequence, R2..R6 phases, then R7 idle
    issue_req("R2");
    repeat (L) step();
    idle_cycles(3, "R7");

    // R8: request in mid-sequence is ignored
    issue_req("R2");
    repeat (4) step();
    req_i = 1'b1;
    step();
    req_i = 1'b0;
    repeat (L - 5) step();
    idle_cycles(1, "R8");

    // R11: back-to-back request in the first idle cycle
    issue_req("R11");
    repeat (L - 1) step();
    // R8: request in the last busy cycle is ignored
    req_i = 1'b1;
    step();
    req_i = 1'b0;
    idle_cycles(4, "R8");

    // R1: sequencer reset in the middle of a sequence aborts it
    req_i = 1'b1;
    step();
    req_i = 1'b0;
    repeat (4) step();
    rst_i = 1'b1;
    step();
    idle_cycles(1, "R1");
    rst_i = 1'b0;
    idle_cycles(3, "R1");

    // R9/R7: a full sequence after the abort
    issue_req("R9");
    repeat (L) step();
    idle_cycles(2, "R7");

    step();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got no end of run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule